// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block is the interrupt front end for 28 general-purpose input pins. Each pin arrives asynchronously and passes through a synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier. Every pin has its own enable for rising edges and its own enable for falling edges. An edge that is enabled sets a sticky pending bit in a status register. Software clears a pending bit by writing a 1 to it.

The lower eleven pins each drive an interrupt request line of their own. The upper seventeen pins share a single request line. A pin in the shared group is masked by clearing both of its edge enables. A separate wake-enable register picks the pending bits that raise the wake output.

Software reaches the four registers through a small port with a write strobe and a combinational read. The register addresses are: 0 for rising enables, 1 for falling enables, 2 for status and 3 for wake enables. Bit n of each register belongs to pin n.

Top module: `gpio_edge_irq`

## Requirements
- R1: A rising edge on a pin whose rising enable (address 0) is set sets that pin's status bit (address 2). A falling edge on a pin with only the rising enable set leaves the status bit at 0.
- R2: A falling edge on a pin whose falling enable (address 1) is set sets that pin's status bit. A rising edge on a pin with only the falling enable set leaves the status bit at 0.
- R3: A pin with both enables set records an edge in either direction.
- R4: A pin with both enables at 0 records no new edge. This is how a pin of the shared group is masked.
- R5: Writing to address 2 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R6: Writing all 1s to address 2 clears every pending bit.
- R7: If a new edge on a pin is detected in the same cycle that software clears that pin's bit, the bit stays set.
- R8: irq_o[n] for n from 0 to 10 is a registered copy of status bit n. It changes one cycle after the status bit changes.
- R9: irq_o[11] is the registered OR of status bits 11 through 27.
- R10: wake_o is the registered OR of the status bits whose wake enable (address 3) is set.
- R11: After reset, all four registers read 0 and every irq_o bit and wake_o are 0.
- R12: A pin change is recorded in status on the third rising clock edge after the change, because it first passes two synchronizer flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 28 | Asynchronous pin levels |
| bus_addr | input | 2 | Register select: 0 rising enables, 1 falling enables, 2 status, 3 wake enables |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 28 | Write data |
| bus_rdata | output | 28 | Read data for the register selected by bus_addr |
| irq_o | output | 12 | Requests: bits 0 to 10 one per pin, bit 11 shared by pins 11 to 27 |
| wake_o | output | 1 | Wake request |

## Verification
The assertions check four rules on every cycle:
- A status bit never sets on a pin whose edge enables were both 0.
- A status bit never falls unless a write of 1 to that bit was made.
- A detected edge always appears in status, even when a clear arrives in the same cycle.
- The request and wake outputs follow the previous cycle's status exactly.

Some behaviour only the bench scenarios can show:
- the edge polarity selection;
- the three-edge latency through the synchronizer;
- the collision of a set and a clear at one exact cycle;
- the full-clear write after random pin activity.

The bench checks these against a model that it derives from the pin history.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register selects for the GPIO edge-detect interrupt unit.
// Assumes a 2-bit register address.
package gpio_irq_pkg;
    typedef enum logic [1:0] {
        SEL_RISE = 2'd0,
        SEL_FALL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_WAKE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Brings each asynchronous pin into the clock domain through two flops and
// keeps one more stage holding the previous synchronized level.
// Assumes each pin is held stable for at least one clock period.
module gpio_pin_sync #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] lvl_prev_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [2:0] stg;
        // Shift the pin level through two sync stages and one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[1:0], pin_i[g]};
        end
        assign lvl_o[g]      = stg[1];
        assign lvl_prev_o[g] = stg[2];
    end
endmodule

// File: rtl/gpio_edge_detect.sv
// Module: gpio_edge_detect
// Flags an enabled edge on each pin by comparing the current synchronized
// level with the previous one. Purely combinational.
module gpio_edge_detect #(
    parameter int WIDTH = 28
) (
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] lvl_prev_i,
    input  logic [WIDTH-1:0] rise_en_i,
    input  logic [WIDTH-1:0] fall_en_i,
    output logic [WIDTH-1:0] hit_o
);
    // A pin hits when it made a transition in a direction it has enabled.
    always_comb begin
        hit_o = ( lvl_i & ~lvl_prev_i & rise_en_i)
              | (~lvl_i &  lvl_prev_i & fall_en_i);
    end
endmodule

// File: rtl/gpio_edge_regs.sv
// Module: gpio_edge_regs
// Holds the edge enables, the wake enables and the sticky status.
// Status bits are cleared by writing 1. A new hit in the same cycle wins.
// Assumes the bus writes one register per cycle.
module gpio_edge_regs
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] hit_i,
    output logic [WIDTH-1:0] rise_en_o,
    output logic [WIDTH-1:0] fall_en_o,
    output logic [WIDTH-1:0] wake_en_o,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] rdata_o
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] clr_mask;

    // Decode the register select and the clear mask of this cycle.
    always_comb begin
        sel      = reg_sel_e'(addr_i);
        clr_mask = (wr_i && sel == SEL_STAT) ? wdata_i : '0;
    end

    // Load the configuration registers from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_o <= '0;
            fall_en_o <= '0;
            wake_en_o <= '0;
        end else if (wr_i) begin
            case (sel)
                SEL_RISE: rise_en_o <= wdata_i;
                SEL_FALL: fall_en_o <= wdata_i;
                SEL_WAKE: wake_en_o <= wdata_i;
                default:  ;
            endcase
        end
    end

    // Update sticky status: clear the bits written as 1, then OR in new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_mask) | hit_i;
    end

    // Return the selected register on the read path.
    always_comb begin
        case (sel)
            SEL_RISE: rdata_o = rise_en_o;
            SEL_FALL: rdata_o = fall_en_o;
            SEL_STAT: rdata_o = status_o;
            default:  rdata_o = wake_en_o;
        endcase
    end
endmodule

// File: rtl/gpio_req_out.sv
// Module: gpio_req_out
// Drives the registered request lines: one line per pin for the low group and
// one OR-ed line for the rest, plus the wake request.
// Assumes NDIRECT is less than WIDTH.
module gpio_req_out #(
    parameter int WIDTH   = 28,
    parameter int NDIRECT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] wake_en_i,
    output logic [NDIRECT:0] irq_o,
    output logic             wake_o
);
    localparam int SHARED_LSB = NDIRECT;

    for (genvar g = 0; g < NDIRECT; g++) begin : g_direct
        // Register the dedicated request for this pin.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_o[g] <= 1'b0;
            else        irq_o[g] <= status_i[g];
        end
    end

    // Register the shared request as the OR of the upper group.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o[NDIRECT] <= 1'b0;
        else        irq_o[NDIRECT] <= |status_i[WIDTH-1:SHARED_LSB];
    end

    // Register the wake request from the wake-qualified pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_o <= 1'b0;
        else        wake_o <= |(status_i & wake_en_i);
    end
endmodule

// File: rtl/gpio_edge_irq.sv
// Module: gpio_edge_irq (top)
// GPIO edge-detect interrupt front end: synchronizer, edge detector, register
// file with write-1-to-clear status, and registered request outputs.
// Assumes one clock domain and a synchronous active-low reset.
module gpio_edge_irq #(
    parameter int PIN_COUNT    = 28,
    parameter int DIRECT_COUNT = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIN_COUNT-1:0]  pin_i,
    input  logic [1:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic [PIN_COUNT-1:0]  bus_wdata,
    output logic [PIN_COUNT-1:0]  bus_rdata,
    output logic [DIRECT_COUNT:0] irq_o,
    output logic                  wake_o
);
    logic [PIN_COUNT-1:0] lvl_now, lvl_prev, hit_vec;
    logic [PIN_COUNT-1:0] rise_en, fall_en, wake_en, status_q;

    gpio_pin_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .lvl_o(lvl_now), .lvl_prev_o(lvl_prev)
    );

    gpio_edge_detect #(.WIDTH(PIN_COUNT)) u_detect (
        .lvl_i(lvl_now), .lvl_prev_i(lvl_prev),
        .rise_en_i(rise_en), .fall_en_i(fall_en), .hit_o(hit_vec)
    );

    gpio_edge_regs #(.WIDTH(PIN_COUNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .hit_i(hit_vec),
        .rise_en_o(rise_en), .fall_en_o(fall_en), .wake_en_o(wake_en),
        .status_o(status_q), .rdata_o(bus_rdata)
    );

    gpio_req_out #(.WIDTH(PIN_COUNT), .NDIRECT(DIRECT_COUNT)) u_req (
        .clk(clk), .rst_n(rst_n), .status_i(status_q), .wake_en_i(wake_en),
        .irq_o(irq_o), .wake_o(wake_o)
    );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
// Module: gpio_edge_irq_chk
// Checker bound into gpio_edge_irq. It relates status, hits, enables and
// outputs across cycles.
module gpio_edge_irq_chk #(
    parameter int WIDTH   = 28,
    parameter int NDIRECT = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] rise_en,
    input logic [WIDTH-1:0] fall_en,
    input logic [WIDTH-1:0] wake_en,
    input logic [WIDTH-1:0] hit_vec,
    input logic [WIDTH-1:0] status,
    input logic [NDIRECT:0] irq_o,
    input logic             wake_o
);
    logic [WIDTH-1:0] clr_seen, en_any;
    // Rebuild the clear mask at the port level and the any-enable mask.
    always_comb begin
        clr_seen = (bus_wr && bus_addr == 2'd2) ? bus_wdata : '0;
        en_any   = rise_en | fall_en;
    end

    // R4: new pending bits appear only on pins with an edge enabled
    a_r4_masked_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~$past(status) & ~$past(en_any)) == '0);

    // R5: a pending bit drops only when a 1 was written to it
    a_r5_clear_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status) & ~status & ~$past(clr_seen)) == '0);

    // R7: every detected edge lands in status, even under a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit_vec) & ~status) == '0);

    // R8: dedicated lines follow the previous status
    a_r8_direct_lines: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[NDIRECT-1:0] == $past(status[NDIRECT-1:0]));

    // R9: shared line is the OR of the upper group one cycle earlier
    a_r9_shared_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[NDIRECT] == $past(|status[WIDTH-1:NDIRECT]));

    // R10: wake follows the wake-qualified pending bits
    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o == $past(|(status & wake_en)));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.WIDTH(PIN_COUNT), .NDIRECT(DIRECT_COUNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rise_en(rise_en), .fall_en(fall_en),
    .wake_en(wake_en), .hit_vec(hit_vec), .status(status_q),
    .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
    localparam int W  = 28;
    localparam int ND = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  pin_i = '0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [ND:0]   irq_o;
    logic          wake_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_edge_irq u_gpio_edge_irq (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [W-1:0] f_status(input logic [W-1:0] old_st,
            input logic [W-1:0] p0, input logic [W-1:0] p1,
            input logic [W-1:0] ren, input logic [W-1:0] fen);
        return old_st | (p1 & ~p0 & ren) | (~p1 & p0 & fen);
    endfunction

    function automatic logic [ND:0] f_irq(input logic [W-1:0] st);
        return {|st[W-1:ND], st[ND-1:0]};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] v, st, ren, fen, wen, np;
        void'($urandom(32'h1234_5eed));
        waitn(4);
        rst_n = 1'b1;
        waitn(1);

        // R11: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R11 reg", v, '0);
        end
        check("R11 irq", W'(irq_o), '0);
        check("R11 wake", W'(wake_o), '0);

        // R1 and R12: rising only on pin 2, exact latency
        wr(2'd0, 28'h4);
        pin_i[2] = 1'b1;
        waitn(2); rd(2'd2, v); check("R12 not yet", v, '0);
        waitn(1); rd(2'd2, v); check("R12 third edge", v, 28'h4);
        check("R8 irq lags status", W'(irq_o), '0);
        waitn(1); check("R8 irq line 2", W'(irq_o), W'(12'h004));
        wr(2'd2, 28'h4);
        pin_i[2] = 1'b0; waitn(4);
        rd(2'd2, v); check("R1 falling ignored", v, '0);

        // R2: falling only on pin 5
        wr(2'd1, 28'h20); wr(2'd0, 28'h0);
        pin_i[5] = 1'b1; waitn(4);
        rd(2'd2, v); check("R2 rising ignored", v, '0);
        pin_i[5] = 1'b0; waitn(4);
        rd(2'd2, v); check("R2 falling seen", v, 28'h20);

        // R5: write 0 keeps, write 1 clears
        wr(2'd2, 28'h0); rd(2'd2, v); check("R5 zero keeps", v, 28'h20);
        wr(2'd2, 28'h20); rd(2'd2, v); check("R5 one clears", v, '0);

        // R3: both edges on pin 20, shared line R9
        wr(2'd0, 28'h10_0000); wr(2'd1, 28'h10_0000);
        pin_i[20] = 1'b1; waitn(4);
        rd(2'd2, v); check("R3 rise", v, 28'h10_0000);
        check("R9 shared line", W'(irq_o), W'(12'h800));
        wr(2'd2, 28'h10_0000);
        pin_i[20] = 1'b0; waitn(4);
        rd(2'd2, v); check("R3 fall", v, 28'h10_0000);
        wr(2'd2, '1);

        // R4: mask pin 20 by clearing both enables
        wr(2'd0, '0); wr(2'd1, '0);
        pin_i[20] = 1'b1; waitn(4); pin_i[20] = 1'b0; waitn(4);
        rd(2'd2, v); check("R4 masked pin", v, '0);
        check("R4 shared quiet", W'(irq_o), '0);

        // R10: wake on pin 7 only when wake-enabled
        wr(2'd0, 28'h180); wr(2'd3, 28'h80);
        pin_i[8] = 1'b1; waitn(4);
        check("R10 no wake", W'(wake_o), '0);
        pin_i[7] = 1'b1; waitn(4);
        check("R10 wake", W'(wake_o), 28'h1);
        wr(2'd2, '1); waitn(1);
        check("R10 wake drops", W'(wake_o), '0);
        pin_i[7] = 1'b0; pin_i[8] = 1'b0; wr(2'd3, '0);

        // R7: clear coinciding with a new edge on pin 3
        wr(2'd0, 28'h8); waitn(3);
        pin_i[3] = 1'b1;
        waitn(2);
        wr(2'd2, 28'h8);
        rd(2'd2, v); check("R7 set wins", v, 28'h8);
        wr(2'd2, 28'h8);
        pin_i[3] = 1'b0; waitn(4);

        // Random mix, R1 R2 R3 R4 R5 R8 R9 R10
        st = '0; wr(2'd2, '1);
        for (int it = 0; it < 60; it++) begin
            ren = W'($urandom); fen = W'($urandom); wen = W'($urandom);
            wr(2'd0, ren); wr(2'd1, fen); wr(2'd3, wen);
            np = pin_i ^ W'($urandom);
            st = f_status(st, pin_i, np, ren, fen);
            pin_i = np;
            waitn(4);
            rd(2'd2, v); check("R1 R2 R3 R4 random status", v, st);
            check("R8 R9 random irq", W'(irq_o), W'(f_irq(st)));
            check("R10 random wake", W'(wake_o), W'(|(st & wen)));
            if ($urandom_range(1, 0) == 1) begin
                v = W'($urandom);
                wr(2'd2, v);
                st = st & ~v;
                rd(2'd2, v); check("R5 random clear", v, st);
            end
        end

        // R6: all ones clears everything
        wr(2'd2, '1);
        rd(2'd2, v); check("R6 full clear", v, '0);
        waitn(1);
        check("R6 irq idle", W'(irq_o), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule